// File: doc/BRIEF.md
# Flow-Control Status Calendar Generator

This block produces the repeating flow-control status stream that a receiver returns to its far-end transmitter. Each port's credit state is a 2-bit code: starving, hungry or satisfied. A programmable calendar RAM maps each calendar slot to a port number. The generator walks the calendar one slot per clock and emits the status of the mapped port on a 2-bit lane. A port may be placed in several slots so that it is reported more often than the others.

A sequence on the lane is built in this order:

- one framing code;
- the calendar, walked a configurable number of times;
- one DIP-2 parity word.

The next framing code follows the parity word at once. The port status inputs, the calendar length and the repetition count are all captured while the framing code is on the lane. This keeps every value within one sequence consistent, and a change made mid-sequence takes effect at the next sequence. Calendar slots are rewritten through a simple one-entry-per-clock write port.

Top module: `stat_cal_gen`

## Requirements
- R1: While rst_n is low, stat_out is 2'b11 and calendar slot i maps to port i mod NUM_PORTS. The first sequence after reset release begins with the framing code.
- R2: Every sequence begins with exactly one cycle of the framing code 2'b11. The first calendar slot follows in the next cycle.
- R3: A calendar slot cycle emits the snapshot status of the port mapped to that slot. The status codes are 2'b00 starving, 2'b01 hungry and 2'b10 satisfied. A slot cycle never emits 2'b11.
- R4: After the framing code, slots 0 to L-1 are emitted in order, where L = cal_len_m1 + 1. This pass is made M = cal_reps_m1 + 1 times in a row, so a sequence lasts L*M + 2 cycles.
- R5: In the cycle after the last slot, the lane carries the DIP-2 word. This word is the bitwise inverse of the XOR of every status code emitted in that sequence's slots. The framing code of the next sequence follows in the next cycle.
- R6: port_status is sampled in the framing cycle. A change to port_status at any later cycle has no effect on the slots of the same sequence.
- R7: cal_len_m1 and cal_reps_m1 are sampled in the framing cycle. Changes made during a sequence take effect at the next sequence.
- R8: When cal_wr_en is high at a clock edge, slot cal_wr_slot maps to cal_wr_port from the next cycle onwards. A slot read in the cycle its write is presented still shows the old port. Any number of slots may map to the same port.
- R9: A port whose port_status field is the reserved value 2'b11 when sampled is reported as 2'b00 (starving).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_status | input | 2*NUM_PORTS | Status code of each port; port p occupies bits [2p+1:2p] |
| cal_len_m1 | input | $clog2(CAL_SLOTS) | Calendar length minus one |
| cal_reps_m1 | input | REP_W | Calendar passes per sequence minus one |
| cal_wr_en | input | 1 | Calendar slot write strobe |
| cal_wr_slot | input | $clog2(CAL_SLOTS) | Slot index to write |
| cal_wr_port | input | $clog2(NUM_PORTS) | Port number stored in the slot |
| stat_out | output | 2 | Status lane: framing code, slot status or DIP-2 word |

## Verification
Two events can fall in the same cycle: a calendar write and the read of that same slot. The bench provokes this by presenting a write to whichever slot is on the lane at that moment. The old port must appear in that cycle, and the new port must appear on the next pass of the calendar. The framing cycle can also coincide with new values on port_status, cal_len_m1 and cal_reps_m1. The bench changes these inputs exactly in framing cycles and again mid-sequence. A cycle-level reference model in the bench decides which values belong to which sequence.

// File: rtl/stat_cal_gen.sv
module stat_cal_gen #(
  parameter int NUM_PORTS = 256,
  parameter int CAL_SLOTS = 256,
  parameter int REP_W     = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int SLOT_W   = $clog2(CAL_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_PORTS-1:0] port_status,
  input  logic [SLOT_W-1:0]      cal_len_m1,
  input  logic [REP_W-1:0]       cal_reps_m1,
  input  logic                   cal_wr_en,
  input  logic [SLOT_W-1:0]      cal_wr_slot,
  input  logic [PORT_W-1:0]      cal_wr_port,
  output logic [1:0]             stat_out
);

  localparam logic [1:0] PH_FRAME = 2'd0;
  localparam logic [1:0] PH_SLOT  = 2'd1;
  localparam logic [1:0] PH_DIP   = 2'd2;

  logic [1:0]             phase;
  logic [PORT_W-1:0]      cal [CAL_SLOTS];
  logic [2*NUM_PORTS-1:0] clean;
  logic [2*NUM_PORTS-1:0] snap;
  logic [SLOT_W-1:0]      slot, len_q;
  logic [REP_W-1:0]       rep, reps_q;
  logic [1:0]             acc;
  logic [PORT_W-1:0]      cur_port;
  logic [1:0]             cur_stat;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_clean
    assign clean[2*g +: 2] = (port_status[2*g +: 2] == 2'b11) ? 2'b00 : port_status[2*g +: 2];
  end

  assign cur_port = cal[slot];
  assign cur_stat = (int'(cur_port) < NUM_PORTS) ? snap[{cur_port, 1'b0} +: 2] : 2'b00;

  always_comb begin
    case (phase)
      PH_SLOT: stat_out = cur_stat;
      PH_DIP:  stat_out = ~acc;
      default: stat_out = 2'b11;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAL_SLOTS; i++) cal[i] <= PORT_W'(i % NUM_PORTS);
    end else if (cal_wr_en) begin
      cal[cal_wr_slot] <= cal_wr_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FRAME;
      snap   <= '0;
      slot   <= '0;
      len_q  <= '0;
      rep    <= '0;
      reps_q <= '0;
      acc    <= '0;
    end else begin
      case (phase)
        PH_FRAME: begin
          snap   <= clean;
          len_q  <= cal_len_m1;
          reps_q <= cal_reps_m1;
          slot   <= '0;
          rep    <= '0;
          acc    <= '0;
          phase  <= PH_SLOT;
        end
        PH_SLOT: begin
          acc <= acc ^ cur_stat;
          if (slot == len_q) begin
            slot <= '0;
            if (rep == reps_q) phase <= PH_DIP;
            else               rep   <= rep + 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: phase <= PH_FRAME;
      endcase
    end
  end

endmodule

// File: rtl/stat_cal_gen_chk.sv
module stat_cal_gen_chk #(
  parameter int NUM_PORTS = 256,
  parameter int SLOT_W    = 8,
  parameter int REP_W     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             phase,
  input logic [1:0]             stat_out,
  input logic [2*NUM_PORTS-1:0] snap,
  input logic [SLOT_W-1:0]      slot,
  input logic [SLOT_W-1:0]      len_q,
  input logic [REP_W-1:0]       reps_q
);

  AST_SLOT_NOT_FRAMING: assert property (@(posedge clk) disable iff (!rst_n) phase == 2'd1 |-> stat_out != 2'b11); // R3
  AST_FRAME_THEN_SLOT:  assert property (@(posedge clk) disable iff (!rst_n) phase == 2'd0 |=> phase == 2'd1 && stat_out != 2'b11); // R2
  AST_DIP_THEN_FRAME:   assert property (@(posedge clk) disable iff (!rst_n) phase == 2'd2 |=> stat_out == 2'b11); // R5
  AST_SLOT_IN_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) phase == 2'd1 |-> slot <= len_q); // R4
  AST_SNAP_HELD:        assert property (@(posedge clk) disable iff (!rst_n) phase != 2'd0 |=> $stable(snap)); // R6
  AST_CFG_HELD:         assert property (@(posedge clk) disable iff (!rst_n) phase != 2'd0 |=> $stable(len_q) && $stable(reps_q)); // R7

endmodule

bind stat_cal_gen stat_cal_gen_chk #(
  .NUM_PORTS(NUM_PORTS),
  .SLOT_W(SLOT_W),
  .REP_W(REP_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .phase(phase),
  .stat_out(stat_out),
  .snap(snap),
  .slot(slot),
  .len_q(len_q),
  .reps_q(reps_q)
);

// File: tb/stat_cal_gen_tb.sv
module stat_cal_gen_tb;
  localparam int NP = 256;
  localparam int CS = 256;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*NP-1:0] port_status = '0;
  logic [7:0]    cal_len_m1 = '0;
  logic [RW-1:0] cal_reps_m1 = '0;
  logic          cal_wr_en = 1'b0;
  logic [7:0]    cal_wr_slot = '0;
  logic [7:0]    cal_wr_port = '0;
  logic [1:0]    stat_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stat_cal_gen u_dut (
    .clk(clk), .rst_n(rst_n), .port_status(port_status),
    .cal_len_m1(cal_len_m1), .cal_reps_m1(cal_reps_m1),
    .cal_wr_en(cal_wr_en), .cal_wr_slot(cal_wr_slot), .cal_wr_port(cal_wr_port),
    .stat_out(stat_out)
  );

  int         m_ph;
  int         m_slot, m_rep, m_len, m_reps;
  logic [1:0] m_acc;
  logic [1:0] m_snap [NP];
  logic [7:0] m_cal [CS];

  function automatic logic [1:0] clean(input logic [1:0] v);
    return (v == 2'b11) ? 2'b00 : v;
  endfunction

  function automatic logic [1:0] exp_out();
    if (m_ph == 1) return m_snap[m_cal[m_slot]];
    if (m_ph == 2) return ~m_acc;
    return 2'b11;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_slot = 0; m_rep = 0; m_len = 0; m_reps = 0; m_acc = 2'b00;
    for (int p = 0; p < NP; p++) m_snap[p] = 2'b00;
    for (int s = 0; s < CS; s++) m_cal[s] = 8'(s % NP);
  endtask

  task automatic model_edge();
    logic [1:0] cur;
    if (m_ph == 0) begin
      for (int p = 0; p < NP; p++) m_snap[p] = clean(port_status[2*p +: 2]);
      m_len = int'(cal_len_m1); m_reps = int'(cal_reps_m1);
      m_slot = 0; m_rep = 0; m_acc = 2'b00; m_ph = 1;
    end else if (m_ph == 1) begin
      cur = exp_out();
      m_acc = m_acc ^ cur;
      if (m_slot == m_len) begin
        m_slot = 0;
        if (m_rep == m_reps) m_ph = 2;
        else m_rep++;
      end else m_slot++;
    end else m_ph = 0;
    if (cal_wr_en) m_cal[cal_wr_slot] = cal_wr_port;
  endtask

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stat_out actual %b expected %b (phase %0d slot %0d)", tag, act, exp, m_ph, m_slot);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    model_edge();
    check(tag, stat_out, exp_out());
  endtask

  task automatic set_port(input int p, input logic [1:0] v);
    port_status[2*p +: 2] = v;
  endtask

  task automatic run_to_frame(input string tag);
    do step(tag); while (m_ph != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    for (int p = 0; p < NP; p++) set_port(p, 2'(p % 3));
    cal_len_m1 = 8'd3;
    cal_reps_m1 = 4'd0;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset framing", stat_out, 2'b11);
    end
    rst_n = 1'b1;
    check("R1 first framing", stat_out, 2'b11);
    step("R2 first slot after framing");
    check("R1 identity map slot0", stat_out, 2'b00);
    step("R1 identity map slot1");
    check("R1 identity map slot1 value", stat_out, 2'b01);
    run_to_frame("R5 dip after short calendar");

    cal_reps_m1 = 4'd2;
    step("R7 reps sampled in framing");
    cal_reps_m1 = 4'd0;
    cal_len_m1 = 8'd1;
    run_to_frame("R4 three passes of four slots");
    run_to_frame("R7 new length next sequence");

    cal_len_m1 = 8'd5;
    cal_reps_m1 = 4'd1;
    for (int s = 0; s < 6; s++) begin
      cal_wr_en = 1'b1; cal_wr_slot = 8'(s); cal_wr_port = (s % 2 == 0) ? 8'd7 : 8'(10 + s);
      step("R8 calendar program");
    end
    cal_wr_en = 1'b0;
    run_to_frame("R8 program settle");
    set_port(7, 2'b10);
    run_to_frame("R8 port 7 in several slots");

    set_port(7, 2'b11);
    run_to_frame("R9 reserved reported starving");
    set_port(7, 2'b01);

    step("R6 framing snapshot");
    for (int p = 0; p < NP; p++) set_port(p, 2'b10);
    run_to_frame("R6 later status ignored");
    run_to_frame("R6 new status next sequence");

    step("R8 same-cycle enter");
    while (m_ph == 1) begin
      if (m_slot == 2 && m_rep == 0) begin
        cal_wr_en = 1'b1; cal_wr_slot = 8'd2; cal_wr_port = 8'd200;
        set_port(200, 2'b01);
      end else cal_wr_en = 1'b0;
      step("R8 write during read of same slot");
    end
    cal_wr_en = 1'b0;
    run_to_frame("R8 write settle");

    cal_len_m1 = 8'd255;
    cal_reps_m1 = 4'd0;
    for (int s = 0; s < CS; s++) begin
      cal_wr_en = 1'b1; cal_wr_slot = 8'(s); cal_wr_port = 8'(255 - s);
      step("R4 full calendar program");
    end
    cal_wr_en = 1'b0;
    for (int i = 0; i < 16; i++) port_status[32*i +: 32] = $urandom;
    run_to_frame("R4 full length settle");
    run_to_frame("R4 full length 256 slots");

    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(0, 3) == 0)
        for (int i = 0; i < 16; i++) port_status[32*i +: 32] = $urandom;
      cal_wr_en = ($urandom_range(0, 9) == 0);
      cal_wr_slot = 8'($urandom_range(0, 15));
      cal_wr_port = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 49) == 0) begin
        cal_len_m1 = 8'($urandom_range(0, 15));
        cal_reps_m1 = 4'($urandom_range(0, 3));
      end
      step("R3 R5 random stream");
    end
    cal_wr_en = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule